// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM channel. It drives the memory through its mandatory power-up sequence once reset is released. First it holds the clock enable low and the command bus deselected for a power-up interval. That interval is derived from the controller clock frequency and a duration in microseconds. It then raises the clock enable with a NOP and steps through a fixed chain of commands: a precharge of all banks, a load of the extended mode register that enables the DLL, a load of the base mode register with the DLL-reset bit set, a second precharge of all banks, and two auto refreshes. The chain ends with a base mode-register load that has the DLL-reset bit cleared.

Every command lasts one cycle and is followed by its own wait of NOP cycles. The wait counts are parameters: row precharge time, mode-register set time and refresh cycle time. A separate counter starts at the DLL-reset load. The ready flag is not raised until that counter has expired, so a read can never follow the DLL reset too early. Once the ready flag is up, the block drives NOP with the clock enable high and leaves the bus to normal traffic logic. Only a new reset clears the flag.

Top module: `ddr_init_seq`

## Requirements
- R1: After reset is released, cke_o stays low and the bus carries DESELECT (cs_n, ras_n, cas_n, we_n = 1111) for exactly PWRUP_CYC = CLK_MHZ*PWRUP_US cycles.
- R2: The first cycle with cke_o high carries a NOP (0111). cke_o then stays high until the next reset.
- R3: After the NOP, exactly seven commands are issued, in this order: PRECHARGE ALL; LOAD MODE with BA=01 and address EMR_VAL; LOAD MODE with BA=00 and address MR_VAL with bit DLL_RST_BIT set; PRECHARGE ALL; AUTO REFRESH; AUTO REFRESH; LOAD MODE with BA=00 and address MR_VAL with bit DLL_RST_BIT cleared.
- R4: The command encodings (cs_n, ras_n, cas_n, we_n) are: PRECHARGE ALL 0010, AUTO REFRESH 0001, LOAD MODE 0000. PRECHARGE ALL drives addr_o bit 10 high with every other address and bank bit low. AUTO REFRESH drives address and bank zero.
- R5: Each command lasts one cycle and is followed only by NOPs. The next command follows it after a fixed number of cycles: 2 cycles after the clock-enable NOP, T_RP+1 after a precharge, T_MRD+1 after a mode load, and T_RFC+1 after a refresh.
- R6: init_done_o rises in cycle max(final mode load + T_MRD + 1, DLL-reset mode load + T_DLL + 1).
- R7: Once init_done_o is high, it stays high and the bus carries NOP with cke_o high until reset.
- R8: A synchronous active-low reset at any point returns the outputs to the power-up state (cke_o low, DESELECT, init_done_o low). The whole sequence then restarts from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke_o | output | 1 | SDRAM clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ROW_W | Row/mode address lines |
| init_done_o | output | 1 | Initialization complete, sticky until reset |

## Verification
A wrong step state appears on the command pins in the very next issue slot. It shows as a command out of order, a wrong bank or mode value, or a missing or extra command. Any of these is visible within one wait interval. A wrong wait counter moves every later command and the ready flag by the same number of cycles, so the exact issue cycle of each command is compared against the sum of the parameter waits. A broken DLL gate shows only as init_done_o rising too early or too late. For that reason a second instance, limited by the mode-load wait, is timed against the first, which is limited by the DLL counter.

// File: rtl/ddr_init_pkg.sv
// Package: shared command and step types for the power-up sequencer.
// Assumes: one command slot per controller clock.
package ddr_init_pkg;

    typedef enum logic [2:0] {
        CMD_DESEL,
        CMD_NOP,
        CMD_PRE,
        CMD_REF,
        CMD_LMR
    } cmd_e;

    typedef enum logic [3:0] {
        ST_PWRUP,
        ST_CKE,
        ST_PRE1,
        ST_EMR,
        ST_MRDLL,
        ST_PRE2,
        ST_REF1,
        ST_REF2,
        ST_MRRUN,
        ST_DONE
    } step_e;

    function automatic int unsigned max_of3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/ddr_init_timer.sv
// Module: loadable down-counter that reports when it has reached zero.
// Assumes: load has priority; the count holds at zero until loaded again.
module ddr_init_timer #(
    parameter int unsigned     W       = 16,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt;

    // Count down towards zero, reloading on request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= RST_VAL;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/ddr_cmd_drive.sv
// Module: maps the abstract command onto the four active-low command pins.
// Assumes: DESELECT drives every pin high.
module ddr_cmd_drive
    import ddr_init_pkg::*;
(
    input  cmd_e cmd,
    output logic cs_n,
    output logic ras_n,
    output logic cas_n,
    output logic we_n
);

    // Decode the command into pin levels.
    always_comb begin
        unique case (cmd)
            CMD_NOP: {cs_n, ras_n, cas_n, we_n} = 4'b0111;
            CMD_PRE: {cs_n, ras_n, cas_n, we_n} = 4'b0010;
            CMD_REF: {cs_n, ras_n, cas_n, we_n} = 4'b0001;
            CMD_LMR: {cs_n, ras_n, cas_n, we_n} = 4'b0000;
            default: {cs_n, ras_n, cas_n, we_n} = 4'b1111;
        endcase
    end

endmodule

// File: rtl/ddr_init_fsm.sv
// Module: step sequencer for the power-up chain. Issues one command per
// step, then waits on the step timer. The last step also waits for the
// DLL timer. Assumes ROW_W > 10 so that the all-bank address bit exists.
module ddr_init_fsm
    import ddr_init_pkg::*;
#(
    parameter int unsigned          ROW_W       = 13,
    parameter int unsigned          BA_W        = 2,
    parameter int unsigned          CNT_W       = 16,
    parameter int unsigned          T_RP        = 3,
    parameter int unsigned          T_MRD       = 2,
    parameter int unsigned          T_RFC       = 10,
    parameter int unsigned          T_DLL       = 200,
    parameter int unsigned          DLL_RST_BIT = 8,
    parameter logic [ROW_W-1:0]     EMR_VAL     = '0,
    parameter logic [ROW_W-1:0]     MR_VAL      = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_zero,
    input  logic              dll_zero,
    output logic              step_load,
    output logic [CNT_W-1:0]  step_load_val,
    output logic              dll_load,
    output logic [CNT_W-1:0]  dll_load_val,
    output cmd_e              cmd,
    output logic [BA_W-1:0]   ba,
    output logic [ROW_W-1:0]  addr,
    output logic              cke,
    output logic              done
);

    localparam logic [ROW_W-1:0] DLL_MASK = ROW_W'(1) << DLL_RST_BIT;
    localparam logic [ROW_W-1:0] ALL_BANK = ROW_W'(1) << 10;

    step_e       step;
    step_e       nxt;
    logic        issue;
    logic        dll_armed;
    logic        advance;
    int unsigned wait_len;

    // Successor of each step in the fixed chain.
    always_comb begin
        unique case (step)
            ST_PWRUP: nxt = ST_CKE;
            ST_CKE:   nxt = ST_PRE1;
            ST_PRE1:  nxt = ST_EMR;
            ST_EMR:   nxt = ST_MRDLL;
            ST_MRDLL: nxt = ST_PRE2;
            ST_PRE2:  nxt = ST_REF1;
            ST_REF1:  nxt = ST_REF2;
            ST_REF2:  nxt = ST_MRRUN;
            default:  nxt = ST_DONE;
        endcase
    end

    // Wait length in NOP cycles that follows the command of each step.
    always_comb begin
        unique case (step)
            ST_PRE1, ST_PRE2:           wait_len = T_RP;
            ST_EMR, ST_MRDLL, ST_MRRUN: wait_len = T_MRD;
            ST_REF1, ST_REF2:           wait_len = T_RFC;
            default:                    wait_len = 1;
        endcase
    end

    assign advance = !issue && step_zero && (step != ST_DONE) &&
                     ((step != ST_MRRUN) || (dll_armed && dll_zero));

    // Step register, one-cycle issue flag and DLL-timer arming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step      <= ST_PWRUP;
            issue     <= 1'b0;
            dll_armed <= 1'b0;
        end else begin
            if (advance) begin
                step  <= nxt;
                issue <= (nxt != ST_DONE);
            end else begin
                issue <= 1'b0;
            end
            if (issue && step == ST_MRDLL)
                dll_armed <= 1'b1;
        end
    end

    assign step_load     = issue;
    assign step_load_val = CNT_W'(wait_len - 1);
    assign dll_load      = issue && (step == ST_MRDLL);
    assign dll_load_val  = CNT_W'(T_DLL - 1);
    assign cke           = (step != ST_PWRUP);
    assign done          = (step == ST_DONE);

    // Command, bank and address for the current slot.
    always_comb begin
        cmd  = CMD_NOP;
        ba   = '0;
        addr = '0;
        if (step == ST_PWRUP) begin
            cmd = CMD_DESEL;
        end else if (issue) begin
            unique case (step)
                ST_PRE1, ST_PRE2: begin
                    cmd  = CMD_PRE;
                    addr = ALL_BANK;
                end
                ST_EMR: begin
                    cmd  = CMD_LMR;
                    ba   = BA_W'(1);
                    addr = EMR_VAL;
                end
                ST_MRDLL: begin
                    cmd  = CMD_LMR;
                    addr = MR_VAL | DLL_MASK;
                end
                ST_MRRUN: begin
                    cmd  = CMD_LMR;
                    addr = MR_VAL & ~DLL_MASK;
                end
                ST_REF1, ST_REF2: cmd = CMD_REF;
                default:          cmd = CMD_NOP;
            endcase
        end
    end

    // R6: the ready state is reached only after the DLL timer has run out.
    p_done_after_dll_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step == ST_DONE) |-> (dll_armed && dll_zero));

    // R5: while the step timer runs, the step does not change.
    p_step_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!issue && !step_zero) |=> $stable(step));

endmodule

// File: rtl/ddr_init_seq.sv
// Module: top of the DDR power-up initialization sequencer. It joins the
// step FSM, a step wait timer, a DLL lock timer and the pin driver.
// Assumes CLK_MHZ*PWRUP_US gives the power-up wait in cycles.
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int unsigned          CLK_MHZ     = 100,
    parameter int unsigned          PWRUP_US    = 200,
    parameter int unsigned          T_RP        = 3,
    parameter int unsigned          T_MRD       = 2,
    parameter int unsigned          T_RFC       = 10,
    parameter int unsigned          T_DLL       = 200,
    parameter int unsigned          ROW_W       = 13,
    parameter int unsigned          BA_W        = 2,
    parameter int unsigned          DLL_RST_BIT = 8,
    parameter logic [ROW_W-1:0]     EMR_VAL     = '0,
    parameter logic [ROW_W-1:0]     MR_VAL      = ROW_W'(13'h0062)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             cke_o,
    output logic             cs_n_o,
    output logic             ras_n_o,
    output logic             cas_n_o,
    output logic             we_n_o,
    output logic [BA_W-1:0]  ba_o,
    output logic [ROW_W-1:0] addr_o,
    output logic             init_done_o
);

    localparam int unsigned PWRUP_CYC = CLK_MHZ * PWRUP_US;
    localparam int unsigned MAX_CNT   = max_of3(PWRUP_CYC, max_of3(T_RP, T_MRD, T_RFC), T_DLL);
    localparam int unsigned CNT_W     = $clog2(MAX_CNT + 1);

    logic             step_zero;
    logic             dll_zero;
    logic             step_load;
    logic             dll_load;
    logic [CNT_W-1:0] step_load_val;
    logic [CNT_W-1:0] dll_load_val;
    cmd_e             cmd;

    ddr_init_fsm #(
        .ROW_W(ROW_W), .BA_W(BA_W), .CNT_W(CNT_W),
        .T_RP(T_RP), .T_MRD(T_MRD), .T_RFC(T_RFC), .T_DLL(T_DLL),
        .DLL_RST_BIT(DLL_RST_BIT), .EMR_VAL(EMR_VAL), .MR_VAL(MR_VAL)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n),
        .step_zero(step_zero), .dll_zero(dll_zero),
        .step_load(step_load), .step_load_val(step_load_val),
        .dll_load(dll_load), .dll_load_val(dll_load_val),
        .cmd(cmd), .ba(ba_o), .addr(addr_o),
        .cke(cke_o), .done(init_done_o)
    );

    ddr_init_timer #(.W(CNT_W), .RST_VAL(CNT_W'(PWRUP_CYC - 1))) step_tmr_i (
        .clk(clk), .rst_n(rst_n), .load(step_load),
        .load_val(step_load_val), .zero(step_zero)
    );

    ddr_init_timer #(.W(CNT_W), .RST_VAL('0)) dll_tmr_i (
        .clk(clk), .rst_n(rst_n), .load(dll_load),
        .load_val(dll_load_val), .zero(dll_zero)
    );

    ddr_cmd_drive drv_i (
        .cmd(cmd), .cs_n(cs_n_o), .ras_n(ras_n_o),
        .cas_n(cas_n_o), .we_n(we_n_o)
    );

    // R1: while the clock enable is low, the bus is deselected.
    p_desel_cke_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cke_o |-> cs_n_o);

    // R2: once raised, the clock enable stays high.
    p_cke_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cke_o |=> cke_o);

    // R7: the ready flag is sticky and comes with NOP and the clock enable high.
    p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        init_done_o |=> init_done_o);

    p_done_nop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        init_done_o |-> (cke_o && {cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0111));

    // R4: precharge-all drives only address bit 10.
    p_pre_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0010) |->
        (addr_o == (ROW_W'(1) << 10) && ba_o == '0));

    // R5: every executable command is followed by a NOP.
    p_cmd_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_o && !(ras_n_o && cas_n_o && we_n_o)) |=>
        ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0111));

endmodule

// File: tb/ddr_init_seq_tb_top.sv
module ddr_init_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_MHZ    = 1;
    localparam int PWRUP_US   = 200;
    localparam int P          = CLK_MHZ * PWRUP_US;
    localparam int T_RP       = 3;
    localparam int T_MRD      = 2;
    localparam int T_RFC      = 10;
    localparam int T_DLL      = 200;
    localparam int T_DLL2     = 8;
    localparam logic [12:0] EMR_V = 13'h0002;
    localparam logic [12:0] MR_V  = 13'h0061;
    localparam logic [12:0] DLLB  = 13'h0100;
    localparam int WATCHDOG   = 5000;

    typedef struct packed {
        logic [3:0]  pins;
        logic [1:0]  ba;
        logic [12:0] addr;
        logic [15:0] gap;
    } vec_t;

    // Expected command chain (R3, R4) with gap from the previous command (R5).
    localparam vec_t VEC [7] = '{
        '{4'b0010, 2'd0, 13'h0400,     16'(P + 2)},
        '{4'b0000, 2'd1, EMR_V,        16'(T_RP + 1)},
        '{4'b0000, 2'd0, MR_V | DLLB,  16'(T_MRD + 1)},
        '{4'b0010, 2'd0, 13'h0400,     16'(T_MRD + 1)},
        '{4'b0001, 2'd0, 13'h0000,     16'(T_RP + 1)},
        '{4'b0001, 2'd0, 13'h0000,     16'(T_RFC + 1)},
        '{4'b0000, 2'd0, MR_V & ~DLLB, 16'(T_RFC + 1)}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke, cs_n, ras_n, cas_n, we_n, done;
    logic [1:0]  ba;
    logic [12:0] addr;
    logic cke2, cs2, ras2, cas2, we2, done2;
    logic [1:0]  ba2;
    logic [12:0] addr2;

    ddr_init_seq #(
        .CLK_MHZ(CLK_MHZ), .PWRUP_US(PWRUP_US), .T_RP(T_RP), .T_MRD(T_MRD),
        .T_RFC(T_RFC), .T_DLL(T_DLL), .EMR_VAL(EMR_V), .MR_VAL(MR_V)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cke_o(cke), .cs_n_o(cs_n), .ras_n_o(ras_n),
        .cas_n_o(cas_n), .we_n_o(we_n), .ba_o(ba), .addr_o(addr), .init_done_o(done)
    );

    ddr_init_seq #(
        .CLK_MHZ(CLK_MHZ), .PWRUP_US(PWRUP_US), .T_RP(T_RP), .T_MRD(T_MRD),
        .T_RFC(T_RFC), .T_DLL(T_DLL2), .EMR_VAL(EMR_V), .MR_VAL(MR_V)
    ) dut2_i (
        .clk(clk), .rst_n(rst_n), .cke_o(cke2), .cs_n_o(cs2), .ras_n_o(ras2),
        .cas_n_o(cas2), .we_n_o(we2), .ba_o(ba2), .addr_o(addr2), .init_done_o(done2)
    );

    initial forever #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    int cyc = 0;

    logic [3:0]  lg_pins [16];
    logic [1:0]  lg_ba   [16];
    logic [12:0] lg_addr [16];
    int          lg_cyc  [16];
    int lg_n, cke_cyc, done_cyc, done2_cyc, lowbad, donedrop, postbad, ckedrop;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Cycles since reset release.
    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    // Port monitor, sampled on the falling edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            lg_n = 0; cke_cyc = -1; done_cyc = -1; done2_cyc = -1;
            lowbad = 0; donedrop = 0; postbad = 0; ckedrop = 0;
        end else begin
            if ({cs_n, ras_n, cas_n, we_n} != 4'hF && {cs_n, ras_n, cas_n, we_n} != 4'h7
                && lg_n < 16) begin
                lg_pins[lg_n] = {cs_n, ras_n, cas_n, we_n};
                lg_ba[lg_n]   = ba;
                lg_addr[lg_n] = addr;
                lg_cyc[lg_n]  = cyc;
                lg_n++;
            end
            if (cke_cyc >= 0 && !cke) ckedrop++;
            if (cke && cke_cyc < 0) begin
                cke_cyc = cyc;
                if ({cs_n, ras_n, cas_n, we_n} != 4'h7) lowbad++;
            end
            if (!cke && {cs_n, ras_n, cas_n, we_n} != 4'hF) lowbad++;
            if (done_cyc >= 0 && !done) donedrop++;
            if (done && {cs_n, ras_n, cas_n, we_n} != 4'h7) postbad++;
            if (done && done_cyc < 0) done_cyc = cyc;
            if (done2 && done2_cyc < 0) done2_cyc = cyc;
        end
    end

    task automatic check_reset_state(string tag);
        chk({tag, " R8 cke"}, int'(cke), 0);
        chk({tag, " R8 pins"}, int'({cs_n, ras_n, cas_n, we_n}), 4'hF);
        chk({tag, " R8 done"}, int'(done), 0);
        chk({tag, " R8 done2"}, int'(done2), 0);
    endtask

    task automatic run_check(string tag);
        int c;
        int c_dll;
        int c_last;
        int exp_done;
        repeat (P + 320) @(negedge clk);
        chk({tag, " R1 cke rise cycle"}, cke_cyc, P);
        chk({tag, " R1 R2 bus while low and first NOP"}, lowbad, 0);
        chk({tag, " R2 cke stays high"}, ckedrop, 0);
        chk({tag, " R3 command count"}, lg_n, 7);
        c = 0;
        for (int i = 0; i < 7; i++) begin
            c = c + int'(VEC[i].gap);
            chk($sformatf("%s R4 pins #%0d", tag, i), int'(lg_pins[i]), int'(VEC[i].pins));
            chk($sformatf("%s R3 bank #%0d", tag, i), int'(lg_ba[i]), int'(VEC[i].ba));
            chk($sformatf("%s R3 addr #%0d", tag, i), int'(lg_addr[i]), int'(VEC[i].addr));
            chk($sformatf("%s R5 cycle #%0d", tag, i), lg_cyc[i], c);
            if (i == 2) c_dll = c;
        end
        c_last = c;
        exp_done = (c_last + T_MRD + 1 > c_dll + T_DLL + 1) ? c_last + T_MRD + 1 : c_dll + T_DLL + 1;
        chk({tag, " R6 done cycle, DLL limited"}, done_cyc, exp_done);
        chk({tag, " R6 done cycle, mode-load limited"}, done2_cyc, c_last + T_MRD + 1);
        chk({tag, " R7 done held"}, donedrop, 0);
        chk({tag, " R7 NOP after done"}, postbad, 0);
        chk({tag, " R7 done level"}, int'(done), 1);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R8 actual=timeout expected=finish");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state("initial");
        #1 rst_n = 1'b1;
        run_check("run1");

        // Reset after completion.
        @(negedge clk); #1 rst_n = 1'b0;
        @(negedge clk);
        check_reset_state("after done");
        repeat (2) @(negedge clk);
        #1 rst_n = 1'b1;

        // Reset in the middle of the chain, then a full restart.
        repeat (P + 12) @(negedge clk);
        chk("mid R2 cke high before reset", int'(cke), 1);
        #1 rst_n = 1'b0;
        @(negedge clk);
        check_reset_state("mid chain");
        repeat (2) @(negedge clk);
        #1 rst_n = 1'b1;
        run_check("run2");
        summary();
    end

endmodule